// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Mode Detection

This block is the digital serial side of a single-channel telephony codec. On the transmit side it keeps the most recent 8-bit code from the encoder in a holding register. When a transmit frame sync arrives, it moves that code into a shift register and sends it most significant bit first on a data output with a separate output enable. An active-low time-slot flag is low for as long as that enable is high. On the receive side it collects 8 serial bits after a receive frame sync. It then presents them as a parallel word together with a one-cycle valid strobe.

The bit clock and both frame syncs are level inputs that are synchronous to the system clock `clk`. The block finds bit-clock and sync edges by comparing each input with its value on the previous `clk` cycle. It works out from the width of the transmit sync pulse whether the line uses one-bit-wide syncs (short mode) or syncs of three or more bit periods (long mode). The mode it finds applies to both directions. Short mode is the state after reset.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset the port is in short mode, `dx_oe` is 0, `tsx_n` is 1 and `rx_valid` is 0.
- R2: In short mode, a transmit sync is `fsx` found high at a falling `bclk` edge (only the first such edge of a pulse counts). The next rising edge sets `dx_oe` and drives bit 7 on `dx`. The next seven rising edges drive bits 6 to 0. The falling edge after the eighth rising edge clears `dx_oe`.
- R3: The word sent is the value of the holding register at the moment the sync is detected. A `tx_load` pulse writes `tx_code` into the holding register. A load made while a word is being sent affects only the next frame.
- R4: `tsx_n` is 0 exactly in the cycles where `dx_oe` is 1.
- R5: In short mode, `fsr` found high at a falling edge (the first of its pulse) arms the receiver. The next eight falling edges capture `dr`, first bit into bit 7. One system clock after the eighth capture, `rx_word` holds the word and `rx_valid` is 1 for exactly one cycle.
- R6: A transmit sync pulse that stays high across three or more falling `bclk` edges selects long mode when it ends. A pulse that spans exactly one falling edge selects short mode when it ends. Any other width leaves the mode unchanged. The mode changes only at the end of an `fsx` pulse.
- R7: In long mode, a rising edge of `fsx` starts a frame. `dx_oe` rises at the later of the `fsx` rise and a `bclk` rise, with bit 7 first. If `bclk` is already high when `fsx` rises, the output turns on one system clock after the `fsx` rise. Bits 6 to 0 follow on the next seven `bclk` rises.
- R8: In long mode, `dx_oe` clears at the later of two events: the falling `bclk` edge after the eighth rising edge, or `fsx` going low.
- R9: In long mode, a rising edge of `fsr` arms the receiver, and the next eight falling `bclk` edges capture the word as in R5.
- R10: A new transmit sync during a word abandons that word. `dx_oe` clears and the new frame runs from the start with the holding register's current value.
- R11: A new receive sync during a word abandons the partial word without a strobe. The next eight falling edges form the word that is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Bit clock level, synchronous to clk |
| fsx | input | 1 | Transmit frame sync level |
| fsr | input | 1 | Receive frame sync level |
| dr | input | 1 | Serial receive data |
| tx_load | input | 1 | Writes tx_code into the transmit holding register |
| tx_code | input | 8 | Encoder code to be sent in the next frame |
| dx | output | 1 | Serial transmit data, valid while dx_oe is 1 |
| dx_oe | output | 1 | Transmit data output enable (high drives the pin) |
| tsx_n | output | 1 | Active-low transmit time-slot flag |
| rx_word | output | 8 | Last received word |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_word |

## Verification
Every output is a register that updates on the `clk` edge where a changed `bclk`, `fsx` or `fsr` level is first seen, so each result is due exactly one system clock after the input change. The bench changes one input on a falling `clk` edge and reads the outputs on the next falling edge. It reads `rx_valid` once more one cycle later to show that the strobe lasts a single cycle. For the long-mode disable, `fsx` is held past the eighth bit, and the bench checks that `dx_oe` holds until one cycle after `fsx` drops.

// File: rtl/pcm_pkg.sv
// Shared definitions for the PCM serial port.
// Assumes every user overrides the defaults through module parameters.
package pcm_pkg;
    parameter int PCM_WORD_W   = 8;
    parameter int PCM_LONG_MIN = 3;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_ARMED,
        TX_SHIFT,
        TX_TAIL
    } tx_state_t;
endpackage

// File: rtl/pcm_edges.sv
// Edge detector for N level inputs that are synchronous to clk.
// Assumes inputs change at most once per clk cycle; rise/fall are combinational
// against the value held from the previous cycle.
module pcm_edges #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Remember the level of this input from the last cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) prev[i] <= 1'b0;
            else        prev[i] <= sig_in[i];
        end
        assign rise[i] = sig_in[i] & ~prev[i];
        assign fall[i] = ~sig_in[i] & prev[i];
    end
endmodule

// File: rtl/pcm_mode_det.sv
// Measures the transmit sync width in falling bit-clock edges and picks the
// frame-sync mode when the pulse ends. It also flags the first falling edge
// of each sync pulse (the short-mode sync point).
// Assumes fsx is synchronous to the bit clock.
module pcm_mode_det #(
    parameter int LONG_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_fall,
    input  logic fsx,
    input  logic fsx_fall,
    output logic sync_short,
    output logic long_mode
);
    localparam int CW = $clog2(LONG_MIN + 1);
    localparam logic [CW-1:0] LIM = CW'(LONG_MIN);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] width_cnt;

    // Count falling bit-clock edges while the sync is high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !fsx)                     width_cnt <= '0;
        else if (bclk_fall && width_cnt < LIM)  width_cnt <= width_cnt + ONE;
    end

    // Decide the mode when the sync pulse ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                               long_mode <= 1'b0;
        else if (fsx_fall && width_cnt >= LIM)    long_mode <= 1'b1;
        else if (fsx_fall && width_cnt == ONE)    long_mode <= 1'b0;
    end

    assign sync_short = fsx & bclk_fall & (width_cnt == '0);

    AST_MODE_AT_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(long_mode) |-> $past(fsx_fall)); // R6
endmodule

// File: rtl/pcm_tx_path.sv
// Transmit side: a holding register written by the encoder, and a shift
// register loaded from it at each sync. The word leaves MSB first on bit-clock
// rising edges. Short and long mode set when the output turns on and off.
// Assumes bclk/fsx are level inputs synchronous to clk.
module pcm_tx_path
    import pcm_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              long_mode,
    input  logic              bclk,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              fsx,
    input  logic              fsx_rise,
    input  logic              sync_short,
    input  logic              tx_load,
    input  logic [WORD_W-1:0] tx_code,
    output logic              dx,
    output logic              dx_oe
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    tx_state_t         state;
    logic [WORD_W-1:0] hold;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  sent;
    logic              start_short;
    logic              start_long;

    assign start_short = sync_short & ~long_mode;
    assign start_long  = fsx_rise & long_mode;

    // Keep the latest encoder code for the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold <= '0;
        else if (tx_load) hold <= tx_code;
    end

    // Frame sequencing: arm, shift eight bits, then release the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            shreg <= '0;
            sent  <= '0;
        end else if (start_short) begin
            state <= TX_ARMED;
            shreg <= hold;
            sent  <= '0;
        end else if (start_long) begin
            shreg <= hold;
            state <= bclk ? TX_SHIFT : TX_ARMED;
            sent  <= bclk ? ONE : '0;
        end else begin
            case (state)
                TX_ARMED: begin
                    if (bclk_rise) begin
                        state <= TX_SHIFT;
                        sent  <= ONE;
                    end
                end
                TX_SHIFT: begin
                    if (bclk_rise && sent < LAST) begin
                        shreg <= {shreg[WORD_W-2:0], 1'b0};
                        sent  <= sent + ONE;
                    end else if (bclk_fall && sent == LAST) begin
                        state <= (long_mode && fsx) ? TX_TAIL : TX_IDLE;
                    end
                end
                TX_TAIL: begin
                    if (!fsx) state <= TX_IDLE;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign dx    = shreg[WORD_W-1];
    assign dx_oe = (state == TX_SHIFT) || (state == TX_TAIL);

    AST_TX_ENABLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dx_oe) |-> ($past(bclk_rise) || $past(fsx_rise && long_mode))); // R7

    AST_TX_DISABLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dx_oe) |-> ($past(bclk_fall) || !$past(fsx) || $past(fsx_rise))); // R8
endmodule

// File: rtl/pcm_rx_path.sv
// Receive side: after a sync, collects WORD_W bits on falling bit-clock edges
// (MSB first) and strobes the assembled word for one cycle.
// Assumes fsr/dr are synchronous to the bit clock.
module pcm_rx_path #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              long_mode,
    input  logic              bclk_fall,
    input  logic              fsr,
    input  logic              fsr_rise,
    input  logic              fsr_fall,
    input  logic              dr,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LASTIDX = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic              seen;
    logic              start;
    logic              busy;
    logic [CNT_W-1:0]  got;
    logic [WORD_W-1:0] shreg;

    // Mark that the current receive sync pulse has met a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || fsr_fall)    seen <= 1'b0;
        else if (fsr && bclk_fall) seen <= 1'b1;
    end

    assign start = long_mode ? fsr_rise : (fsr & bclk_fall & ~seen);

    // Capture bits and publish the word after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            got      <= '0;
            shreg    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                got  <= '0;
            end else if (busy && bclk_fall) begin
                shreg <= {shreg[WORD_W-2:0], dr};
                if (got == LASTIDX) begin
                    busy     <= 1'b0;
                    rx_word  <= {shreg[WORD_W-2:0], dr};
                    rx_valid <= 1'b1;
                end else begin
                    got <= got + ONE;
                end
            end
        end
    end

    AST_RX_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R5

    AST_RX_STROBE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bclk_fall)); // R9
endmodule

// File: rtl/pcm_serial_port.sv
// Top of the PCM serial port: edge detection, sync-mode detection and the
// transmit and receive paths. Assumes all inputs are synchronous to clk.
module pcm_serial_port
    import pcm_pkg::*;
#(
    parameter int WORD_W   = PCM_WORD_W,
    parameter int LONG_MIN = PCM_LONG_MIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fsx,
    input  logic              fsr,
    input  logic              dr,
    input  logic              tx_load,
    input  logic [WORD_W-1:0] tx_code,
    output logic              dx,
    output logic              dx_oe,
    output logic              tsx_n,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    logic [2:0] lv;
    logic [2:0] rise;
    logic [2:0] fall;
    logic       sync_short;
    logic       long_mode;

    assign lv = {fsr, fsx, bclk};

    pcm_edges #(.N(3)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (lv),
        .rise   (rise),
        .fall   (fall)
    );

    pcm_mode_det #(.LONG_MIN(LONG_MIN)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_fall  (fall[0]),
        .fsx        (fsx),
        .fsx_fall   (fall[1]),
        .sync_short (sync_short),
        .long_mode  (long_mode)
    );

    pcm_tx_path #(.WORD_W(WORD_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .long_mode  (long_mode),
        .bclk       (bclk),
        .bclk_rise  (rise[0]),
        .bclk_fall  (fall[0]),
        .fsx        (fsx),
        .fsx_rise   (rise[1]),
        .sync_short (sync_short),
        .tx_load    (tx_load),
        .tx_code    (tx_code),
        .dx         (dx),
        .dx_oe      (dx_oe)
    );

    pcm_rx_path #(.WORD_W(WORD_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .long_mode (long_mode),
        .bclk_fall (fall[0]),
        .fsr       (fsr),
        .fsr_rise  (rise[2]),
        .fsr_fall  (fall[2]),
        .dr        (dr),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid)
    );

    assign tsx_n = ~dx_oe;
endmodule

// File: tb/sim_pcm_serial_port.sv
// Directed bench for the PCM serial port; one task per scenario.
module sim_pcm_serial_port;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b0;
    logic       fsx = 1'b0;
    logic       fsr = 1'b0;
    logic       dr = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_code = 8'h00;
    logic       dx, dx_oe, tsx_n, rx_valid;
    logic [7:0] rx_word;

    logic       s_oe, s_dx, s_tsx, s_val, s_val2;
    logic [7:0] s_word;
    int         n_chk = 0;
    int         n_bad = 0;
    int         n_val = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    pcm_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsx(fsx), .fsr(fsr), .dr(dr),
        .tx_load(tx_load), .tx_code(tx_code), .dx(dx), .dx_oe(dx_oe),
        .tsx_n(tsx_n), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Snapshot all outputs one clk after an input change.
    task automatic snap();
        @(negedge clk);
        s_oe = dx_oe; s_dx = dx; s_tsx = tsx_n; s_val = rx_valid; s_word = rx_word;
        if (s_val) n_val++;
        check("R4 tsx_n vs dx_oe", int'(s_tsx), int'(!s_oe));
    endtask

    // Drive one bit-clock edge, then sample.
    task automatic edge_b(input logic v);
        @(negedge clk) bclk = v;
        snap();
        @(negedge clk) s_val2 = rx_valid;
        if (s_val) check("R5 strobe one cycle", int'(s_val2), 0);
        repeat (H - 2) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] c);
        @(negedge clk) begin tx_code = c; tx_load = 1'b1; end
        @(negedge clk) tx_load = 1'b0;
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        snap();
        check("R1 dx_oe after reset", int'(s_oe), 0);
        check("R1 tsx_n after reset", int'(s_tsx), 1);
        check("R1 rx_valid after reset", int'(s_val), 0);
    endtask

    // Short-mode frame; a new code is loaded mid-word (R3).
    task automatic short_tx(input logic [7:0] c, input string tag);
        load(c);
        fsx = 1'b1;
        edge_b(1'b1);
        edge_b(1'b0);
        check({tag, " armed, off"}, int'(s_oe), 0);
        fsx = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i == 3) load(~c);
            edge_b(1'b1);
            check({tag, " R2 oe on rise"}, int'(s_oe), 1);
            check({tag, " R2/R3 bit"}, int'(s_dx), int'(c[7-i]));
            edge_b(1'b0);
            check({tag, " R2 oe after fall"}, int'(s_oe), (i < 7) ? 1 : 0);
        end
    endtask

    task automatic t_short_rx(input logic [7:0] d);
        n_val = 0;
        fsr = 1'b1;
        edge_b(1'b1);
        edge_b(1'b0);
        fsr = 1'b0;
        for (int i = 0; i < 8; i++) begin
            dr = d[7-i];
            edge_b(1'b1);
            edge_b(1'b0);
        end
        check("R5 strobe count", n_val, 1);
        check("R5 word", int'(s_word), int'(d));
    endtask

    task automatic t_tx_abandon(input logic [7:0] c, input logic [7:0] e);
        load(c);
        fsx = 1'b1; edge_b(1'b1); edge_b(1'b0); fsx = 1'b0;
        for (int i = 0; i < 3; i++) begin edge_b(1'b1); edge_b(1'b0); end
        load(e);
        fsx = 1'b1;
        edge_b(1'b1);
        edge_b(1'b0);
        check("R10 old word dropped", int'(s_oe), 0);
        fsx = 1'b0;
        for (int i = 0; i < 8; i++) begin
            edge_b(1'b1);
            check("R10 restarted bit", int'(s_dx), int'(e[7-i]));
            edge_b(1'b0);
        end
        check("R10 off after word", int'(s_oe), 0);
    endtask

    task automatic t_rx_abandon(input logic [7:0] d);
        n_val = 0;
        fsr = 1'b1; edge_b(1'b1); edge_b(1'b0); fsr = 1'b0;
        for (int i = 0; i < 4; i++) begin dr = 1'b1; edge_b(1'b1); edge_b(1'b0); end
        fsr = 1'b1; edge_b(1'b1); edge_b(1'b0); fsr = 1'b0;
        for (int i = 0; i < 8; i++) begin dr = d[7-i]; edge_b(1'b1); edge_b(1'b0); end
        check("R11 single strobe", n_val, 1);
        check("R11 word after resync", int'(s_word), int'(d));
    endtask

    // Wide fsx pulse in short mode; switches to long mode at its end.
    task automatic t_train_long();
        fsx = 1'b1;
        for (int i = 0; i < 10; i++) begin
            edge_b(1'b1);
            edge_b(1'b0);
            if (i == 2) fsx = 1'b0;
        end
        check("R6 idle after training", int'(s_oe), 0);
    endtask

    // fsx rises with bclk low: enable waits for the bclk rise.
    task automatic t_long_a(input logic [7:0] g);
        load(g);
        fsx = 1'b1;
        snap();
        check("R7 wait for bclk rise", int'(s_oe), 0);
        for (int i = 0; i < 8; i++) begin
            edge_b(1'b1);
            check("R6/R7 long oe", int'(s_oe), 1);
            check("R7 long bit", int'(s_dx), int'(g[7-i]));
            edge_b(1'b0);
            if (i == 2) fsx = 1'b0;
            check("R8 off at fall after 8th", int'(s_oe), (i < 7) ? 1 : 0);
        end
    endtask

    // fsx rises with bclk high; fsx held past the word.
    task automatic t_long_b(input logic [7:0] h);
        load(h);
        edge_b(1'b1);
        fsx = 1'b1;
        snap();
        check("R7 on at fsx rise", int'(s_oe), 1);
        check("R7 sign bit", int'(s_dx), int'(h[7]));
        edge_b(1'b0);
        for (int i = 1; i < 8; i++) begin
            edge_b(1'b1);
            check("R7 long bit b", int'(s_dx), int'(h[7-i]));
            edge_b(1'b0);
            check("R8 held while fsx high", int'(s_oe), 1);
        end
        edge_b(1'b1);
        edge_b(1'b0);
        check("R8 still held", int'(s_oe), 1);
        fsx = 1'b0;
        snap();
        check("R8 off when fsx drops", int'(s_oe), 0);
        check("R4 tsx_n released", int'(s_tsx), 1);
    endtask

    task automatic t_long_rx(input logic [7:0] d);
        n_val = 0;
        fsr = 1'b1;
        for (int i = 0; i < 8; i++) begin
            dr = d[7-i];
            edge_b(1'b1);
            edge_b(1'b0);
            if (i == 2) fsr = 1'b0;
        end
        check("R9 strobe count", n_val, 1);
        check("R9 word", int'(s_word), int'(d));
    endtask

    task automatic t_back_short(input logic [7:0] j);
        fsx = 1'b1;
        edge_b(1'b1);
        edge_b(1'b0);
        fsx = 1'b0;
        for (int i = 0; i < 9; i++) begin edge_b(1'b1); edge_b(1'b0); end
        check("R6 idle before short frame", int'(s_oe), 0);
        short_tx(j, "R6 back to short");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        t_reset();
        short_tx(8'hA5, "R2 short");
        t_short_rx(8'h3C);
        t_tx_abandon(8'hF0, 8'h96);
        t_rx_abandon(8'h5A);
        t_train_long();
        t_long_a(8'hC3);
        t_long_b(8'h69);
        t_long_rx(8'hB2);
        t_back_short(8'h1E);
        summary();
    end
endmodule